// File: doc/BRIEF.md
# Dual-Channel Hit Readout Event Checker

This block gathers sparse hit words from the two detector channels of one module. Both channels run at the same time. Each channel delivers 32-bit words with a valid/ready handshake and marks the end of its event with a separate strobe. Words are parked in a small staging store per channel. Nothing is kept permanently until both channels have closed the event.

Once both channels have closed the event, the block checks it for consistency. Both channels must hold the same number of hits. The 9-bit event number in bits 31:23 of the first word of each channel must agree. Neither channel may have sent more words than its staging store holds. A consistent event is copied into two 16-bit FIFOs: one holds the upper halves and one the lower halves. An output stage merges the two FIFOs onto a single 16-bit streaming port. An inconsistent event is discarded and a one-cycle front-end reset pulse is raised. Every resolved event, accepted or discarded, ends with a one-cycle done pulse.

Top module: `rdo_event_checker`

## Requirements
- R1: After reset, and while no event is being copied, `ch_ready_o[c]` is high as long as the FIFOs have room. Once channel c's end strobe is taken (`ch_eoe_i[c]` with `ch_ready_o[c]` high), `ch_ready_o[c]` stays low until the event is resolved. The other channel can still deliver words in that time.
- R2: An event is accepted when the two channels hold equal, non-zero hit counts, no channel overflowed, and the event numbers match. All of channel 0's words then come out in arrival order, followed by all of channel 1's words. Each word is sent as bits 31:16 first and then bits 15:0.
- R3: When the hit counts differ, no data reaches the output, and `fe_reset_o` is high for exactly one cycle.
- R4: When both channels hold hits but the event numbers in bits 31:23 of their first words differ, the event is discarded with the same one-cycle `fe_reset_o` pulse and no output.
- R5: A channel that sends more than STAGE_DEPTH words in one event causes the event to be discarded with a `fe_reset_o` pulse.
- R6: Each resolved event produces exactly one one-cycle `done_o` pulse. This pulse coincides with `fe_reset_o` on a discard. If both channels close an event with zero hits, the event gives `done_o` only, with no reset and no output.
- R7: Both channel ready signals are low whenever the free FIFO space is less than 2*STAGE_DEPTH words. While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` holds its value.
- R8: In reset, `out_valid_o`, `fe_reset_o` and `done_o` are low and both channel ready signals are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid_i | input | 2 | Word valid, one bit per channel |
| ch_word_i | input | 2x32 | Hit word per channel: event number 31:23, channel address 22:12, ADC value 11:0 |
| ch_eoe_i | input | 2 | End-of-event strobe per channel |
| ch_ready_o | output | 2 | Channel can accept a word or end strobe |
| out_valid_o | output | 1 | Output half-word valid |
| out_ready_i | input | 1 | Downstream accepts the half-word |
| out_data_o | output | 16 | Output half-word |
| fe_reset_o | output | 1 | One-cycle front-end reset on a discarded event |
| done_o | output | 1 | One-cycle pulse when an event is resolved |

## Verification
Some properties are checked by assertions on every cycle:
- the single-cycle width of the reset pulse and its overlap with done;
- that the output word holds steady under back-pressure;
- that the two half-word FIFOs stay in step and never overflow or underflow.

The bench's directed scenarios are needed for everything else:
- whether an event is accepted or discarded, for each cause: count mismatch, event-number mismatch, overflow and empty events;
- the exact channel-0-then-channel-1 half-word order;
- the per-channel ready behaviour after an end strobe;
- the point at which FIFO occupancy blocks the input.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int EVT_MSB = 31;
    localparam int EVT_LSB = 23;
    localparam int NUM_CH  = 2;

    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_COPY    = 1'b1
    } rdo_state_e;
endpackage

// File: rtl/rdo_stage_buf.sv
module rdo_stage_buf #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [W-1:0]   data_i,
    input  logic           clear_i,
    input  logic [IW-1:0]  rd_idx_i,
    output logic [W-1:0]   rd_data_o,
    output logic [W-1:0]   first_o,
    output logic [CNW-1:0] count_o,
    output logic           ovf_o
);
    typedef struct packed {
        logic [CNW-1:0] cnt;
        logic           ovf;
    } buf_st_t;

    buf_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_store;

    always_comb begin
        st_d     = st_q;
        do_store = 1'b0;
        if (clear_i) begin
            st_d = '0;
        end else if (wr_i) begin
            if (st_q.cnt == CNW'(DEPTH)) begin
                st_d.ovf = 1'b1;
            end else begin
                do_store   = 1'b1;
                st_d.cnt   = st_q.cnt + CNW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_store) mem[st_q.cnt[IW-1:0]] <= data_i;
    end

    assign rd_data_o = mem[rd_idx_i];
    assign first_o   = mem[0];
    assign count_o   = st_q.cnt;
    assign ovf_o     = st_q.ovf;
endmodule

// File: rtl/rdo_half_fifo.sv
module rdo_half_fifo #(
    parameter int DEPTH = 1024,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  data_i,
    input  logic          pop_i,
    output logic [W-1:0]  head_o,
    output logic          empty_o,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push_i) st_d.wp = st_q.wp + AW'(1);
        if (pop_i)  st_d.rp = st_q.rp + AW'(1);
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem[st_q.wp] <= data_i;
    end

    assign head_o  = mem[st_q.rp];
    assign empty_o = (st_q.cnt == '0);
    assign count_o = st_q.cnt;

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (st_q.cnt != CW'(DEPTH)) || pop_i);
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/rdo_event_checker.sv
module rdo_event_checker
    import rdo_pkg::*;
#(
    parameter int STAGE_DEPTH = 32,
    parameter int FIFO_DEPTH  = 1024
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             ch_valid_i,
    input  logic [NUM_CH-1:0][WORD_W-1:0] ch_word_i,
    input  logic [NUM_CH-1:0]             ch_eoe_i,
    output logic [NUM_CH-1:0]             ch_ready_o,
    output logic                          out_valid_o,
    input  logic                          out_ready_i,
    output logic [HALF_W-1:0]             out_data_o,
    output logic                          fe_reset_o,
    output logic                          done_o
);
    localparam int IW    = (STAGE_DEPTH > 1) ? $clog2(STAGE_DEPTH) : 1;
    localparam int CNW   = $clog2(STAGE_DEPTH + 1);
    localparam int FCW   = $clog2(FIFO_DEPTH) + 1;
    localparam int LIMIT = FIFO_DEPTH - 2 * STAGE_DEPTH;

    typedef struct packed {
        rdo_state_e        state;
        logic [NUM_CH-1:0] eoe_seen;
        logic              rd_ch;
        logic [IW-1:0]     rd_idx;
        logic              phase;
        logic              fe_rst;
        logic              done;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [WORD_W-1:0] rd_data [NUM_CH];
    logic [WORD_W-1:0] first_w [NUM_CH];
    logic [CNW-1:0]    cnt     [NUM_CH];
    logic [NUM_CH-1:0] ovf;
    logic [NUM_CH-1:0] wr;
    logic              clear;

    logic              push, pop, room;
    logic [HALF_W-1:0] hi_head, lo_head;
    logic              hi_empty, lo_empty;
    logic [FCW-1:0]    hi_cnt, lo_cnt;
    logic [WORD_W-1:0] copy_word;

    assign room = (hi_cnt <= FCW'(LIMIT));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_stage
        assign ch_ready_o[g] = (st_q.state == ST_COLLECT) && room && !st_q.eoe_seen[g];
        assign wr[g]         = ch_valid_i[g] && ch_ready_o[g];

        rdo_stage_buf #(.DEPTH(STAGE_DEPTH), .W(WORD_W)) i_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (wr[g]),
            .data_i   (ch_word_i[g]),
            .clear_i  (clear),
            .rd_idx_i (st_q.rd_idx),
            .rd_data_o(rd_data[g]),
            .first_o  (first_w[g]),
            .count_o  (cnt[g]),
            .ovf_o    (ovf[g])
        );
    end

    assign copy_word = st_q.rd_ch ? rd_data[1] : rd_data[0];

    always_comb begin
        logic bad;
        st_d        = st_q;
        st_d.fe_rst = 1'b0;
        st_d.done   = 1'b0;
        clear       = 1'b0;
        push        = 1'b0;
        bad = (|ovf) || (cnt[0] != cnt[1]) ||
              ((cnt[0] != '0) &&
               (first_w[0][EVT_MSB:EVT_LSB] != first_w[1][EVT_MSB:EVT_LSB]));

        case (st_q.state)
            ST_COLLECT: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (ch_eoe_i[c] && ch_ready_o[c]) st_d.eoe_seen[c] = 1'b1;
                end
                if (&st_q.eoe_seen) begin
                    if (bad || cnt[0] == '0) begin
                        st_d.fe_rst   = bad;
                        st_d.done     = 1'b1;
                        st_d.eoe_seen = '0;
                        clear         = 1'b1;
                    end else begin
                        st_d.state  = ST_COPY;
                        st_d.rd_ch  = 1'b0;
                        st_d.rd_idx = '0;
                    end
                end
            end
            ST_COPY: begin
                push = 1'b1;
                if (CNW'(st_q.rd_idx) + CNW'(1) == cnt[st_q.rd_ch]) begin
                    st_d.rd_idx = '0;
                    if (!st_q.rd_ch) begin
                        st_d.rd_ch = 1'b1;
                    end else begin
                        st_d.state    = ST_COLLECT;
                        st_d.eoe_seen = '0;
                        st_d.done     = 1'b1;
                        clear         = 1'b1;
                    end
                end else begin
                    st_d.rd_idx = st_q.rd_idx + IW'(1);
                end
            end
            default: st_d.state = ST_COLLECT;
        endcase

        pop = 1'b0;
        if (out_valid_o && out_ready_i) begin
            st_d.phase = !st_q.phase;
            pop        = st_q.phase;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rdo_half_fifo #(.DEPTH(FIFO_DEPTH), .W(HALF_W)) i_fifo_hi (
        .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(copy_word[31:16]),
        .pop_i(pop), .head_o(hi_head), .empty_o(hi_empty), .count_o(hi_cnt)
    );

    rdo_half_fifo #(.DEPTH(FIFO_DEPTH), .W(HALF_W)) i_fifo_lo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(copy_word[15:0]),
        .pop_i(pop), .head_o(lo_head), .empty_o(lo_empty), .count_o(lo_cnt)
    );

    assign out_valid_o = !hi_empty;
    assign out_data_o  = st_q.phase ? lo_head : hi_head;
    assign fe_reset_o  = st_q.fe_rst;
    assign done_o      = st_q.done;

    assert_rst_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fe_reset_o |=> !fe_reset_o);
    assert_rst_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fe_reset_o |-> done_o);
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
    assert_fifo_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt == lo_cnt) && (hi_empty == lo_empty));
endmodule

// File: tb/test_rdo_event_checker.sv
module test_rdo_event_checker;
    localparam int SD = 4;
    localparam int FD = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       ch_valid = '0;
    logic [1:0][31:0] ch_word = '0;
    logic [1:0]       ch_eoe = '0;
    logic [1:0]       ch_ready;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [15:0]      out_data;
    logic             fe_reset;
    logic             done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [15:0] exp_q [$];
    int rst_seen, done_seen;

    always #2.5 clk = ~clk;

    rdo_event_checker #(.STAGE_DEPTH(SD), .FIFO_DEPTH(FD)) i_rdo_event_checker (
        .clk(clk), .rst_n(rst_n), .ch_valid_i(ch_valid), .ch_word_i(ch_word),
        .ch_eoe_i(ch_eoe), .ch_ready_o(ch_ready), .out_valid_o(out_valid),
        .out_ready_i(out_ready), .out_data_o(out_data), .fe_reset_o(fe_reset),
        .done_o(done)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int ev, input int ch, input int i);
        return {9'(ev), 11'(ch * 16 + i + 3), 12'(i * 37 + ch * 5 + ev)};
    endfunction

    task automatic add_exp(input int ev0, input int ev1, input int n);
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < n; i++) begin
                logic [31:0] w = mk(c == 0 ? ev0 : ev1, c, i);
                exp_q.push_back(w[31:16]);
                exp_q.push_back(w[15:0]);
            end
    endtask

    task automatic send_pair(input int n0, input int n1, input int ev0, input int ev1);
        int m = (n0 > n1) ? n0 : n1;
        for (int i = 0; i < m; i++) begin
            @(negedge clk);
            ch_valid = {1'(i < n1), 1'(i < n0)};
            ch_word[0] = mk(ev0, 0, i);
            ch_word[1] = mk(ev1, 1, i);
        end
        @(negedge clk);
        ch_valid = '0;
        ch_eoe = 2'b11;
        @(negedge clk);
        ch_eoe = '0;
    endtask

    task automatic send_one(input int c, input int n, input int ev);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ch_valid[c] = 1'b1;
            ch_word[c] = mk(ev, c, i);
        end
        @(negedge clk);
        ch_valid[c] = 1'b0;
        ch_eoe[c] = 1'b1;
        @(negedge clk);
        ch_eoe[c] = 1'b0;
    endtask

    task automatic wait_resolve();
        rst_seen = 0;
        done_seen = 0;
        for (int k = 0; k < 30; k++) begin
            if (fe_reset) rst_seen++;
            if (done) done_seen++;
            @(negedge clk);
        end
    endtask

    task automatic drain(input string tag);
        int n = exp_q.size();
        int got = 0;
        out_ready = 1'b1;
        for (int k = 0; k < 4 * n + 10 && got < n; k++) begin
            if (out_valid) begin
                check(out_data == exp_q[got], tag, out_data, exp_q[got]);
                got++;
            end
            @(negedge clk);
        end
        check(got == n, {tag, " count"}, got, n);
        check(!out_valid, {tag, " empty after"}, out_valid, 0);
        out_ready = 1'b0;
        exp_q.delete();
    endtask

    task automatic t_reset();
        check(!out_valid && !fe_reset && !done, "R8 idle outputs", {out_valid, fe_reset, done}, 0);
        check(ch_ready == 2'b11, "R8 ready", ch_ready, 3);
    endtask

    task automatic t_match();
        send_pair(3, 3, 5, 5);
        wait_resolve();
        check(done_seen == 1, "R6 done once on accept", done_seen, 1);
        check(rst_seen == 0, "R2 no reset on accept", rst_seen, 0);
        add_exp(5, 5, 3);
        drain("R2 order");
    endtask

    task automatic t_count_mismatch();
        send_pair(2, 1, 6, 6);
        wait_resolve();
        check(rst_seen == 1, "R3 reset pulse", rst_seen, 1);
        check(done_seen == 1, "R6 done with reject", done_seen, 1);
        check(!out_valid, "R3 nothing stored", out_valid, 0);
    endtask

    task automatic t_event_mismatch();
        send_pair(2, 2, 3, 4);
        wait_resolve();
        check(rst_seen == 1, "R4 reset pulse", rst_seen, 1);
        check(!out_valid, "R4 nothing stored", out_valid, 0);
    endtask

    task automatic t_overflow();
        send_pair(SD + 1, SD + 1, 9, 9);
        wait_resolve();
        check(rst_seen == 1, "R5 reset on overflow", rst_seen, 1);
        check(!out_valid, "R5 nothing stored", out_valid, 0);
    endtask

    task automatic t_empty();
        send_pair(0, 0, 0, 0);
        wait_resolve();
        check(done_seen == 1 && rst_seen == 0, "R6 empty event", {done_seen, rst_seen}, 1);
        check(!out_valid, "R6 empty no output", out_valid, 0);
    endtask

    task automatic t_staggered();
        send_one(0, 2, 11);
        check(ch_ready == 2'b10, "R1 ready after eoe", ch_ready, 2);
        send_one(1, 2, 11);
        wait_resolve();
        check(ch_ready == 2'b11, "R1 ready restored", ch_ready, 3);
        check(done_seen == 1 && rst_seen == 0, "R2 staggered accept", {done_seen, rst_seen}, 1);
        add_exp(11, 11, 2);
        drain("R2 staggered order");
    endtask

    task automatic t_backpressure();
        logic [15:0] held;
        send_pair(SD, SD, 7, 7);
        wait_resolve();
        check(ch_ready == 2'b11, "R7 ready at limit", ch_ready, 3);
        send_pair(1, 1, 8, 8);
        wait_resolve();
        check(ch_ready == 2'b00, "R7 ready low when full", ch_ready, 0);
        held = out_data;
        repeat (3) @(negedge clk);
        check(out_valid && out_data == held, "R7 hold under stall", out_data, held);
        add_exp(7, 7, SD);
        add_exp(8, 8, 1);
        drain("R7 drain order");
        check(ch_ready == 2'b11, "R7 ready after drain", ch_ready, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_match();
        t_count_mismatch();
        t_event_mismatch();
        t_overflow();
        t_empty();
        t_staggered();
        t_backpressure();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule